// File: doc/BRIEF.md
# Synchronous Buck Phase Gate Control

This block is the digital core of one synchronous buck phase. A PWM level arrives already sorted by outside comparators into high, low or mid-level. The block turns it into two gate enables, one for the high-side switch and one for the low-side switch. Between the two conducting states it always inserts a gap with both switches off. The high side is held on for a guaranteed minimum time. A mid-level PWM that lasts long enough parks the phase with both switches off. When a valid level comes back, the phase leaves that parked state after a fixed wake delay.

Three inputs gate the whole phase: a disable input (active low), a supply-good flag and a synchronous reset. Each one forces both enables off. With the zero-current mode selected, the low side is dropped once the inductor current reaches zero. A zero-crossing flag signals this, and it is only heeded after a blanking interval. The low side then stays off until the next high PWM. A separate thermal warning output, active low, follows a digital temperature code with set and clear hysteresis. It has no effect on switching.

All delays are given in nanoseconds and turned into whole clock cycles, rounded up, with a minimum of one. In the requirements, an edge that "samples" a value is a rising clock edge at which the input holds that value. PWM encoding: `2'b01` is high, `2'b00` is low, and any code with bit 1 set is mid-level.

Top module: `buck_phase_ctrl`

## Requirements
- R1: When the phase is running steadily, PWM high gives hs_on=1, ls_on=0, and PWM low gives hs_on=0, ls_on=1.
- R2: hs_on and ls_on are never both 1. A high-to-low PWM change leaves exactly DT_LS cycles with both off before ls_on rises. A low-to-high change leaves exactly DT_HS cycles with both off before hs_on rises.
- R3: If PWM is mid-level at HOLDOFF consecutive edges, both outputs go off after the HOLDOFF-th edge and stay off. A mid-level run of HOLDOFF-1 edges changes neither output.
- R4: From the all-off state, the output that matches the valid level turns on after edge 1+TRI_EXIT, counting the first edge that samples the valid level as edge 1. If a mid-level is sampled before that, the block returns to all-off.
- R5: If dsbl_n is sampled low, both outputs are off after that edge, whatever the other inputs are. After release, start-up follows R4.
- R6: With zcd_en_n=0, zero_cross is ignored until ls_on has been 1 for BLANK cycles. After that, zero_cross=1 clears ls_on at the next edge. ls_on then stays 0 while PWM is low. A later PWM high turns hs_on on after DT_HS cycles.
- R7: With zcd_en_n=1, zero_cross has no effect on ls_on.
- R8: Once hs_on rises, it stays 1 for at least MIN_ON cycles, even if PWM goes low sooner. If PWM stays high longer, hs_on stays 1 for as long as PWM is high.
- R9: therm_warn_n goes to 0 after an edge that samples temp_code >= TEMP_SET, and to 1 after an edge that samples temp_code < TEMP_CLR. Between the two thresholds it keeps its value. It never changes the gate outputs.
- R10: If supply_ok is sampled low, both outputs are off after that edge. Once supply_ok returns, start-up follows R4.
- R11: A synchronous reset gives hs_on=0, ls_on=0 and therm_warn_n=1.
- R12: In zero-current mode, a mid-level that lasts HOLDOFF edges turns the low side off even when zero_cross stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_lvl | input | 2 | Classified PWM level: 01 high, 00 low, 1x mid-level |
| dsbl_n | input | 1 | Phase disable, active low |
| zcd_en_n | input | 1 | Zero-current mode select, active low |
| zero_cross | input | 1 | Inductor current has reached zero |
| supply_ok | input | 1 | Logic supply is good |
| temp_code | input | TEMP_W | Junction temperature code |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |
| therm_warn_n | output | 1 | Thermal warning, active low |

## Verification
The hardest case to reach is a zero crossing inside the blanking window. The low side has to be entered fresh, so its on-time counter starts from one, and zero_cross must already be asserted during that window. The bench sets PWM high long enough to clear the minimum on-time. It then drops PWM and raises zero_cross on the same cycle. This keeps zero_cross asserted through the dead time and the whole blanking interval, so the output must stay on for exactly BLANK cycles and fall on the next edge. The minimum on-time is covered by a sweep of high-pulse lengths, each followed by a measurement of the resulting on-time and dead-time gap.

// File: rtl/buck_phase_ctrl.sv
module buck_phase_ctrl #(
  parameter int CLK_NS      = 10,
  parameter int DT_HS_NS    = 10,
  parameter int DT_LS_NS    = 15,
  parameter int HOLDOFF_NS  = 130,
  parameter int TRI_EXIT_NS = 30,
  parameter int BLANK_NS    = 40,
  parameter int MIN_ON_NS   = 30,
  parameter int TEMP_W      = 8,
  parameter int TEMP_SET    = 160,
  parameter int TEMP_CLR    = 135
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        pwm_lvl,
  input  logic              dsbl_n,
  input  logic              zcd_en_n,
  input  logic              zero_cross,
  input  logic              supply_ok,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              hs_on,
  output logic              ls_on,
  output logic              therm_warn_n
);

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int DT_HS_C  = to_cyc(DT_HS_NS);
  localparam int DT_LS_C  = to_cyc(DT_LS_NS);
  localparam int HOLD_C   = to_cyc(HOLDOFF_NS);
  localparam int EXIT_C   = to_cyc(TRI_EXIT_NS);
  localparam int BLANK_C  = to_cyc(BLANK_NS);
  localparam int MINON_C  = to_cyc(MIN_ON_NS);
  localparam int M1 = (DT_HS_C > DT_LS_C) ? DT_HS_C : DT_LS_C;
  localparam int M2 = (EXIT_C > BLANK_C) ? EXIT_C : BLANK_C;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int MAX_C = (M3 > MINON_C) ? M3 : MINON_C;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam int TRI_W = $clog2(HOLD_C + 1);

  localparam logic [CNT_W-1:0] DT_HS_V = CNT_W'(DT_HS_C);
  localparam logic [CNT_W-1:0] DT_LS_V = CNT_W'(DT_LS_C);
  localparam logic [CNT_W-1:0] EXIT_V  = CNT_W'(EXIT_C);
  localparam logic [CNT_W-1:0] BLANK_V = CNT_W'(BLANK_C);
  localparam logic [CNT_W-1:0] MINON_V = CNT_W'(MINON_C);
  localparam logic [CNT_W-1:0] MAX_V   = CNT_W'(MAX_C);
  localparam logic [TRI_W-1:0] HOLD_V  = TRI_W'(HOLD_C);
  localparam logic [TRI_W-1:0] HOLD_M1 = TRI_W'(HOLD_C - 1);
  localparam logic [TEMP_W-1:0] SET_V  = TEMP_W'(TEMP_SET);
  localparam logic [TEMP_W-1:0] CLR_V  = TEMP_W'(TEMP_CLR);

  typedef enum logic [2:0] {
    S_OFF, S_EXIT, S_DT_HS, S_HS, S_DT_LS, S_LS, S_DE
  } phase_e;

  phase_e            state, nxt;
  logic [CNT_W-1:0]  cnt;
  logic [TRI_W-1:0]  tri_cnt;

  wire pwm_hi  = (pwm_lvl == 2'b01);
  wire pwm_lo  = (pwm_lvl == 2'b00);
  wire pwm_mid = pwm_lvl[1];
  wire tri_hit = pwm_mid && (tri_cnt >= HOLD_M1);
  wire stop    = !dsbl_n || !supply_ok;

  always_comb begin
    nxt = state;
    if (stop) nxt = S_OFF;
    else begin
      case (state)
        S_OFF:   if (!pwm_mid) nxt = S_EXIT;
        S_EXIT:  if (pwm_mid) nxt = S_OFF;
                 else if (cnt >= EXIT_V) nxt = pwm_hi ? S_HS : S_LS;
        S_DT_HS: if (tri_hit) nxt = S_OFF;
                 else if (cnt >= DT_HS_V) nxt = S_HS;
        S_HS:    if (tri_hit) nxt = S_OFF;
                 else if (pwm_lo && cnt >= MINON_V) nxt = S_DT_LS;
        S_DT_LS: if (tri_hit) nxt = S_OFF;
                 else if (cnt >= DT_LS_V) nxt = S_LS;
        S_LS:    if (tri_hit) nxt = S_OFF;
                 else if (pwm_hi) nxt = S_DT_HS;
                 else if (!zcd_en_n && zero_cross && cnt >= BLANK_V) nxt = S_DE;
        S_DE:    if (tri_hit) nxt = S_OFF;
                 else if (pwm_hi) nxt = S_DT_HS;
        default: nxt = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_OFF;
      cnt     <= '0;
      tri_cnt <= '0;
      hs_on   <= 1'b0;
      ls_on   <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state)  cnt <= CNT_W'(1);
      else if (cnt < MAX_V) cnt <= cnt + 1'b1;
      if (!pwm_mid)           tri_cnt <= '0;
      else if (tri_cnt < HOLD_V) tri_cnt <= tri_cnt + 1'b1;
      hs_on <= (nxt == S_HS);
      ls_on <= (nxt == S_LS);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     therm_warn_n <= 1'b1;
    else if (temp_code >= SET_V) therm_warn_n <= 1'b0;
    else if (temp_code < CLR_V)  therm_warn_n <= 1'b1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(hs_on && ls_on)); // R2
  AST_HS_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_on) |-> !$past(ls_on)); // R2
  AST_LS_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_on) |-> !$past(hs_on)); // R2
  AST_DSBL_OFF: assert property (@(posedge clk) disable iff (rst)
    !dsbl_n |=> (!hs_on && !ls_on)); // R5
  AST_SUPPLY_OFF: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (!hs_on && !ls_on)); // R10
  AST_ZCD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (zcd_en_n && ls_on && pwm_lo && dsbl_n && supply_ok) |=> ls_on); // R7
  AST_THERM_SET: assert property (@(posedge clk) disable iff (rst)
    (temp_code >= SET_V) |=> !therm_warn_n); // R9
  AST_THERM_CLR: assert property (@(posedge clk) disable iff (rst)
    (temp_code < CLR_V) |=> therm_warn_n); // R9

endmodule

// File: tb/tb_buck_phase_ctrl.sv
module tb_buck_phase_ctrl;
  localparam logic [1:0] LO = 2'b00, HI = 2'b01, MID = 2'b10;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] pwm_lvl = LO;
  logic dsbl_n = 1'b1, zcd_en_n = 1'b1, zero_cross = 1'b0, supply_ok = 1'b1;
  logic [7:0] temp_code = 8'd25;
  logic hs_on, ls_on, therm_warn_n;
  int total = 0, fails = 0;

  always #5 clk = ~clk;

  buck_phase_ctrl #(
    .CLK_NS(10), .DT_HS_NS(20), .DT_LS_NS(30), .HOLDOFF_NS(50),
    .TRI_EXIT_NS(30), .BLANK_NS(40), .MIN_ON_NS(30),
    .TEMP_W(8), .TEMP_SET(160), .TEMP_CLR(135)
  ) dut (
    .clk(clk), .rst(rst), .pwm_lvl(pwm_lvl), .dsbl_n(dsbl_n),
    .zcd_en_n(zcd_en_n), .zero_cross(zero_cross), .supply_ok(supply_ok),
    .temp_code(temp_code), .hs_on(hs_on), .ls_on(ls_on),
    .therm_warn_n(therm_warn_n)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [1:0] exp);
    chk({hs_on, ls_on} == exp, tag, int'({hs_on, ls_on}), int'(exp));
  endtask

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int exp_flag;
    cyc(3);
    chk_out("R11 reset outputs", 2'b00);
    chk(therm_warn_n == 1'b1, "R11 reset flag", int'(therm_warn_n), 1);
    rst = 1'b0;

    cyc(3); chk_out("R4 wake wait", 2'b00);
    cyc(1); chk_out("R4 wake low side", 2'b01);

    pwm_lvl = HI;
    cyc(1); chk_out("R2 gap before hs", 2'b00);
    cyc(1); chk_out("R2 gap before hs", 2'b00);
    cyc(1); chk_out("R1 hs on", 2'b10);
    cyc(5); chk_out("R1 hs steady", 2'b10);
    pwm_lvl = LO;
    cyc(1); chk_out("R2 gap before ls", 2'b00);
    cyc(2); chk_out("R2 gap before ls", 2'b00);
    cyc(1); chk_out("R1 ls on", 2'b01);
    cyc(3); chk_out("R1 ls steady", 2'b01);

    for (int len = 1; len <= 6; len++) begin
      int on_c, gap, ovl, exp_on;
      pwm_lvl = HI;
      cyc(3); chk_out("R1 pulse start", 2'b10);
      on_c = 1; gap = 0; ovl = 0;
      repeat (len - 1) begin cyc(1); if (hs_on) on_c++; end
      pwm_lvl = LO;
      repeat (12) begin
        cyc(1);
        if (hs_on) on_c++;
        if (!hs_on && !ls_on) gap++;
        if (hs_on && ls_on) ovl++;
      end
      exp_on = (len > 3) ? len : 3;
      chk(on_c == exp_on, "R8 hs on-time", on_c, exp_on);
      chk(gap == 3, "R2 dead cycles", gap, 3);
      chk(ovl == 0, "R2 overlap", ovl, 0);
      chk_out("R1 ls after pulse", 2'b01);
    end

    pwm_lvl = MID;
    cyc(4); chk_out("R3 short mid", 2'b01);
    pwm_lvl = LO;
    cyc(1); chk_out("R3 short mid no effect", 2'b01);
    pwm_lvl = MID;
    cyc(4); chk_out("R3 before holdoff", 2'b01);
    cyc(1); chk_out("R3 holdoff off", 2'b00);
    cyc(3); chk_out("R3 stays off", 2'b00);
    pwm_lvl = HI;
    cyc(2); chk_out("R4 wake partial", 2'b00);
    pwm_lvl = MID;
    cyc(5); chk_out("R4 aborted wake", 2'b00);
    pwm_lvl = HI;
    cyc(3); chk_out("R4 wake wait hi", 2'b00);
    cyc(1); chk_out("R4 wake high side", 2'b10);
    pwm_lvl = MID;
    cyc(4); chk_out("R3 hs hold", 2'b10);
    cyc(1); chk_out("R3 hs holdoff off", 2'b00);
    pwm_lvl = LO;
    cyc(3); chk_out("R4 wake wait lo", 2'b00);
    cyc(1); chk_out("R4 wake lo", 2'b01);

    zero_cross = 1'b1;
    cyc(6); chk_out("R7 zero_cross ignored", 2'b01);
    zero_cross = 1'b0;

    zcd_en_n = 1'b0;
    pwm_lvl = HI;
    cyc(3); chk_out("R6 hs first", 2'b10);
    cyc(3);
    pwm_lvl = LO; zero_cross = 1'b1;
    cyc(4); chk_out("R6 ls enters", 2'b01);
    cyc(3); chk_out("R6 blanking holds ls", 2'b01);
    cyc(1); chk_out("R6 ls dropped", 2'b00);
    zero_cross = 1'b0;
    cyc(4); chk_out("R6 stays off while low", 2'b00);
    pwm_lvl = HI;
    cyc(2); chk_out("R6 gap before hs", 2'b00);
    cyc(1); chk_out("R6 hs after emulation", 2'b10);
    cyc(3);
    pwm_lvl = LO;
    cyc(4); chk_out("R12 ls on", 2'b01);
    pwm_lvl = MID;
    cyc(4); chk_out("R12 before holdoff", 2'b01);
    cyc(1); chk_out("R12 ls off without crossing", 2'b00);
    pwm_lvl = LO;
    cyc(4); chk_out("R12 wake", 2'b01);
    zcd_en_n = 1'b1;

    pwm_lvl = HI; dsbl_n = 1'b0;
    cyc(1); chk_out("R5 disable", 2'b00);
    cyc(5); chk_out("R5 disable held", 2'b00);
    dsbl_n = 1'b1;
    cyc(3); chk_out("R5 release wait", 2'b00);
    cyc(1); chk_out("R5 release wake", 2'b10);
    dsbl_n = 1'b0;
    cyc(1); chk_out("R5 disable from hs", 2'b00);
    dsbl_n = 1'b1;
    cyc(4); chk_out("R5 wake again", 2'b10);

    supply_ok = 1'b0;
    cyc(1); chk_out("R10 supply low", 2'b00);
    cyc(3); chk_out("R10 supply held", 2'b00);
    supply_ok = 1'b1;
    cyc(3); chk_out("R10 resume wait", 2'b00);
    cyc(1); chk_out("R10 resume", 2'b10);

    exp_flag = 1;
    for (int t = 100; t < 200; t++) begin
      temp_code = 8'(t);
      cyc(1);
      if (t >= 160) exp_flag = 0; else if (t < 135) exp_flag = 1;
      chk(int'(therm_warn_n) == exp_flag, "R9 rising sweep", int'(therm_warn_n), exp_flag);
    end
    for (int t = 199; t >= 100; t--) begin
      temp_code = 8'(t);
      cyc(1);
      if (t >= 160) exp_flag = 0; else if (t < 135) exp_flag = 1;
      chk(int'(therm_warn_n) == exp_flag, "R9 falling sweep", int'(therm_warn_n), exp_flag);
    end
    temp_code = 8'd170;
    cyc(1);
    chk(therm_warn_n == 1'b0, "R9 warn set", int'(therm_warn_n), 0);
    chk_out("R9 switching unaffected", 2'b10);

    rst = 1'b1;
    cyc(1);
    chk_out("R11 reset in run", 2'b00);
    chk(therm_warn_n == 1'b1, "R11 flag reset", int'(therm_warn_n), 1);
    rst = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule